// File: doc/BRIEF.md
# Control-Register Watchdog Timer

This block is a watchdog timer whose control bits and down-counter share one 8-bit register. Bit 0 is the activation bit C, bit 1 is the software-reset bit SR, and bits 7:2 form the six-bit down-counter T. Software refreshes the watchdog by writing the whole register. The block assumes that the core has already divided its clock down to a tick strobe. While the watchdog is active, T falls by one on every tick. The block raises a one-cycle chip reset request when T's top bit drops from 1 to 0, or when software writes SR as 0.

A strap input selects hardware activation, where the watchdog runs from reset. Without the strap, software activates the watchdog by writing C as 1. Once active, the watchdog cannot be switched off by software; only a chip reset does that. While it is active, the block tells the core to handle a STOP request as WAIT, so the timer keeps running.

A three-state machine sequences the block. In IDLE the watchdog is disabled. In RUN it is active and counting. In TRIP the reset request is driven for one cycle. The transitions are:
- IDLE to RUN on an activating write with SR high, or when the strap is high.
- IDLE to TRIP on an activating write with SR low.
- RUN to TRIP on expiry or on a write with SR low.
- TRIP to RUN when the strap is high, otherwise TRIP to IDLE.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset the register reads 0xFE when hw_arm is low (C=0, SR=1, T=63). It reads 0xFF when hw_arm is high (active).
- R2: While the watchdog is disabled, ticks leave T unchanged. A write stores T from bits 7:2 and SR from bit 1, and activates the watchdog if bit 0 is 1.
- R3: While the watchdog is active and there is no write, each tick lowers T by one. T wraps from 0 to 63 without a reset request.
- R4: A tick with the watchdog active and T equal to 32 (only the top bit set) raises rst_req in the following cycle.
- R5: A write with bit 1 (SR) at 0 raises rst_req in the following cycle when the watchdog is active or the same write activates it.
- R6: A write to an active watchdog loads T and SR, but C stays 1 whatever bit 0 carries.
- R7: rst_req is high for exactly one cycle. In the next cycle the register reads its reset value again: 0xFE, or 0xFF when hw_arm is high.
- R8: stop_as_wait follows stop_req while the watchdog is active and is low while it is disabled. Ticks keep lowering T while stop_req is high.
- R9: When a write and a tick arrive in the same cycle, the written value is loaded and the tick is dropped.
- R10: With hw_arm high, the watchdog is active from reset and stays active after every reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_arm | input | 1 | Hardware-activation strap, held static |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write value: bits 7:2 T, bit 1 SR, bit 0 C |
| tick | input | 1 | One-cycle strobe from the clock prescaler |
| stop_req | input | 1 | Core requests STOP |
| rd_data | output | 8 | Current register value, same layout as wr_data |
| rst_req | output | 1 | One-cycle chip reset request |
| stop_as_wait | output | 1 | Core must treat STOP as WAIT |

## Verification
The assertions check the following on every cycle:
- the reset request is a single-cycle pulse;
- the register reloads after each pulse;
- the RUN state never falls back to IDLE without passing through TRIP;
- the strap keeps the watchdog active;
- an expiring tick always produces a request;
- ticks leave the count alone while the watchdog is disabled.

Only the directed scenarios show the rest: the exact countdown values, the wrap from 0 to 63 without a request, the immunity of C to writes, the software-reset write, write-over-tick priority, and the STOP-to-WAIT substitution under both activation modes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_t,
    input  logic             wr_sr,
    input  logic             tick,
    input  logic             active,
    input  logic             in_run,
    input  logic             reload,
    output logic [CNT_W-1:0] t_q,
    output logic             sr_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] T_FULL = '1;
    localparam logic [CNT_W-1:0] T_EDGE = {1'b1, {(CNT_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q  <= T_FULL;
            sr_q <= 1'b1;
        end else if (reload) begin
            t_q  <= T_FULL;
            sr_q <= 1'b1;
        end else if (wr_en) begin
            t_q  <= wr_t;
            sr_q <= wr_sr;
        end else if (tick && active) begin
            t_q  <= t_q - 1'b1;
        end
    end

    // next decrement clears the top bit
    always_comb expire = in_run && tick && !wr_en && (t_q == T_EDGE);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr_en && !reload) |=> $stable(t_q));
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_arm,
    input  logic wr_en,
    input  logic wr_c,
    input  logic wr_sr,
    input  logic expire,
    input  logic stop_req,
    output logic active,
    output logic in_run,
    output logic reload,
    output logic rst_req,
    output logic stop_as_wait
);
    wd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= hw_arm ? WD_RUN : WD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (wr_en && wr_c) state_d = wr_sr ? WD_RUN : WD_TRIP;
                else if (hw_arm)   state_d = WD_RUN;
            end
            WD_RUN: begin
                if (wr_en && !wr_sr) state_d = WD_TRIP;
                else if (expire)     state_d = WD_TRIP;
            end
            WD_TRIP: state_d = hw_arm ? WD_RUN : WD_IDLE;
            default: state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        active  = 1'b0;
        in_run  = 1'b0;
        reload  = 1'b0;
        rst_req = 1'b0;
        unique case (state_q)
            WD_IDLE: ;
            WD_RUN: begin
                active = 1'b1;
                in_run = 1'b1;
            end
            WD_TRIP: begin
                active  = 1'b1;
                reload  = 1'b1;
                rst_req = 1'b1;
            end
            default: ;
        endcase
        stop_as_wait = active && stop_req;
    end

    // R6
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN) |=> (state_q != WD_IDLE));
    // R7
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R10
    hw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_arm |-> active);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
    parameter int CNT_W = 6,
    localparam int REG_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_arm,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tick,
    input  logic             stop_req,
    output logic [REG_W-1:0] rd_data,
    output logic             rst_req,
    output logic             stop_as_wait
);
    localparam logic [CNT_W-1:0] T_EDGE = {1'b1, {(CNT_W-1){1'b0}}};

    logic             active, in_run, reload, expire, sr_q;
    logic [CNT_W-1:0] t_q;

    wdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hw_arm(hw_arm),
        .wr_en(wr_en), .wr_c(wr_data[0]), .wr_sr(wr_data[1]),
        .expire(expire), .stop_req(stop_req),
        .active(active), .in_run(in_run), .reload(reload),
        .rst_req(rst_req), .stop_as_wait(stop_as_wait)
    );

    wdog_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_t(wr_data[REG_W-1:2]), .wr_sr(wr_data[1]),
        .tick(tick), .active(active), .in_run(in_run), .reload(reload),
        .t_q(t_q), .sr_q(sr_q), .expire(expire)
    );

    always_comb rd_data = {t_q, sr_q, active};

    // R4
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_data[0] && !wr_en && !rst_req &&
         rd_data[REG_W-1:2] == T_EDGE) |=> rst_req);
    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (rd_data[REG_W-1:1] == '1) && (rd_data[0] == hw_arm));
endmodule

// File: tb/wdog_ctrl_test.sv
module wdog_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_arm = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b0;
    logic       stop_req = 1'b0;
    logic [7:0] rd_data;
    logic       rst_req, stop_as_wait;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_arm(hw_arm), .wr_en(wr_en),
        .wr_data(wr_data), .tick(tick), .stop_req(stop_req),
        .rd_data(rd_data), .rst_req(rst_req), .stop_as_wait(stop_as_wait)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic hw);
        @(negedge clk);
        rst_n = 1'b0; hw_arm = hw; wr_en = 1'b0; tick = 1'b0; stop_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 reset value soft", rd_data, 8'hFE);
        check("R1 no request", {7'd0, rst_req}, 8'd0);
    endtask

    task automatic t_idle();
        do_reset(1'b0);
        do_tick(); do_tick(); do_tick();
        check("R2 idle ticks ignored", rd_data, 8'hFE);
        do_write(8'h42);
        check("R2 idle write stores", rd_data, 8'h42);
        do_tick();
        check("R2 idle stored value holds", rd_data, 8'h42);
        do_write(8'h43);
        check("R2 activation", rd_data, 8'h43);
    endtask

    task automatic t_count();
        do_reset(1'b0);
        do_write(8'h07);
        do_tick();
        check("R3 decrement to 0", rd_data, 8'h03);
        do_tick();
        check("R3 wrap to 63", rd_data, 8'hFF);
        check("R3 wrap no request", {7'd0, rst_req}, 8'd0);
    endtask

    task automatic t_expire();
        do_reset(1'b0);
        do_write(8'h87);
        do_tick();
        check("R4 count 32", rd_data, 8'h83);
        check("R4 no early request", {7'd0, rst_req}, 8'd0);
        do_tick();
        check("R4 expiry request", {7'd0, rst_req}, 8'd1);
        @(negedge clk);
        check("R7 single pulse", {7'd0, rst_req}, 8'd0);
        check("R7 reload soft", rd_data, 8'hFE);
    endtask

    task automatic t_swreset();
        do_reset(1'b0);
        do_write(8'hFF);
        do_write(8'hA1);
        check("R5 SR write request", {7'd0, rst_req}, 8'd1);
        @(negedge clk);
        check("R7 reload after SR", rd_data, 8'hFE);
        do_write(8'h01);
        check("R5 activating SR=0 request", {7'd0, rst_req}, 8'd1);
        @(negedge clk);
        check("R7 pulse end", {7'd0, rst_req}, 8'd0);
    endtask

    task automatic t_noclear();
        do_reset(1'b0);
        do_write(8'h53);
        do_write(8'hFE);
        check("R6 C stays set", rd_data, 8'hFF);
        check("R6 no request", {7'd0, rst_req}, 8'd0);
    endtask

    task automatic t_stop();
        do_reset(1'b0);
        @(negedge clk);
        stop_req = 1'b1;
        #1;
        check("R8 idle stop passes", {7'd0, stop_as_wait}, 8'd0);
        do_write(8'hF3);
        check("R8 active stop as wait", {7'd0, stop_as_wait}, 8'd1);
        do_tick();
        check("R8 count during stop", rd_data, 8'hEF);
        @(negedge clk);
        stop_req = 1'b0;
        #1;
        check("R8 follows stop_req", {7'd0, stop_as_wait}, 8'd0);
    endtask

    task automatic t_prio();
        do_reset(1'b0);
        do_write(8'hFF);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hA3; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check("R9 write beats tick", rd_data, 8'hA3);
        do_write(8'h83);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h83; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check("R9 write suppresses expiry", {7'd0, rst_req}, 8'd0);
    endtask

    task automatic t_hw();
        do_reset(1'b1);
        check("R1 reset value hw", rd_data, 8'hFF);
        check("R10 active from reset", {7'd0, rd_data[0]}, 8'd1);
        @(negedge clk);
        stop_req = 1'b1;
        #1;
        check("R10 hw stop as wait", {7'd0, stop_as_wait}, 8'd1);
        @(negedge clk);
        stop_req = 1'b0;
        do_write(8'h81);
        check("R10 hw SR request", {7'd0, rst_req}, 8'd1);
        @(negedge clk);
        check("R10 hw reload active", rd_data, 8'hFF);
        do_tick();
        check("R10 hw counting", rd_data, 8'hFB);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_count();
        t_expire();
        t_swreset();
        t_noclear();
        t_stop();
        t_prio();
        t_hw();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule